// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running 16-bit timer counter at the moment a chosen transition appears on an external capture pin. The pin is asynchronous to the timer clock. It passes through a synchroniser, and an edge detector then compares successive synchronised samples. A run-time select bit chooses which transition counts: high-to-low or low-to-high. On a qualifying transition, the counter value is stored in a capture register and an event flag is raised. If the interrupt enable is set, that flag drives an interrupt request.

The capture register can also act as the counter's TOP limit. When the mode input says it does, the pin is cut off from the capture logic, so no capture and no flag set can happen. In that mode, software loads the register through a plain write strobe. The flag is cleared by writing 1 to a clear strobe.

Top module: `capture_unit`

## Requirements
- R1: After reset the capture register reads 0, the flag is 0 and the interrupt request is 0.
- R2: With the edge select at 1, a low-to-high transition on the capture pin causes a capture, and a high-to-low transition does not.
- R3: With the edge select at 0, a high-to-low transition on the capture pin causes a capture, and a low-to-high transition does not.
- R4: The capture register and the flag change at the third rising clock edge after the pin transition, counting from the first edge that samples the new pin level. The stored value is the counter input present at that third edge.
- R5: A capture sets the flag. The flag stays set until cleared. A later capture overwrites the register even while the flag is still set.
- R6: A clear strobe at 1 clears the flag at the next edge. If a capture occurs at the same edge, the flag ends up set.
- R7: The interrupt request is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R8: While the TOP-mode input is 1, pin transitions change neither the capture register nor the flag.
- R9: A write strobe loads the write data into the capture register at the next edge when the TOP-mode input is 1. When the TOP-mode input is 0, the write strobe has no effect on the register.
- R10: Changing the edge select while the pin is steady causes no capture. Leaving TOP mode while the pin is steady also causes no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| edge_rise_i | input | 1 | 1 selects low-to-high, 0 selects high-to-low |
| top_mode_i | input | 1 | 1 while the capture register serves as counter TOP |
| count_i | input | 16 | Current timer counter value |
| wr_cap_i | input | 1 | Write strobe for the capture register |
| wr_data_i | input | 16 | Data for the capture register write |
| flag_clr_i | input | 1 | Clear strobe for the capture flag |
| irq_en_i | input | 1 | Capture interrupt enable |
| cap_val_o | output | 16 | Capture register contents |
| cap_flag_o | output | 1 | Capture event flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The hardest case to reach is a capture that lands on the same edge as a flag clear. The clear strobe must be raised exactly at the edge where the synchronised transition emerges, three edges after the pin moves. The bench reaches this with a single task that moves the pin and then drives a fresh counter value and an optional clear strobe at each of the following edges, so the collision edge is chosen by construction. Randomised pin levels, edge selects and enable values, mixed with directed steps for TOP mode and for select changes, cover the cases where nothing may be captured.

// File: rtl/capture_pkg.sv
package capture_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  // True when the step from prev to cur is the transition chosen by sel.
  function automatic logic edge_match(input edge_sel_e sel, input logic prev,
                                      input logic cur);
    logic hit;
    if (sel == EDGE_RISE) hit = cur & ~prev;
    else                  hit = prev & ~cur;
    return hit;
  endfunction

  // Interrupt request from flag and enable.
  function automatic logic irq_level(input logic flag, input logic en);
    return flag & en;
  endfunction

endpackage

// File: rtl/pin_edge_detect.sv
module pin_edge_detect
  import capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_rise_i,
  input  logic block_i,
  output logic edge_hit_o,
  output logic cap_evt_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          synced;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign synced = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;

  // Only successive synchronised samples are compared; the select bit is not history.
  assign edge_hit_o = edge_match(edge_sel_e'(edge_rise_i), prev_q, synced);
  assign cap_evt_o  = edge_hit_o & ~block_i;

  // R8
  block_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |-> !cap_evt_o);

  // R10
  steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (synced == prev_q) |-> !edge_hit_o);

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             top_mode_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cap_q_o
);
  logic wr_ok;
  assign wr_ok = wr_i & top_mode_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cap_q_o <= '0;
    else if (cap_evt_i)  cap_q_o <= count_i;
    else if (wr_ok)      cap_q_o <= wr_data_i;

  // R4
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_i |=> (cap_q_o == $past(count_i)));

  // R9
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_mode_i && !cap_evt_i) |=> $stable(cap_q_o));

  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode_i && wr_i && !cap_evt_i) |=> (cap_q_o == $past(wr_data_i)));

endmodule

// File: rtl/capture_flag.sv
module capture_flag
  import capture_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;

  assign irq_o = irq_level(flag_o, irq_en_i);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin_i,
  input  logic             edge_rise_i,
  input  logic             top_mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_cap_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic edge_hit_w;
  logic cap_evt_w;

  pin_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .edge_rise_i(edge_rise_i),
    .block_i(top_mode_i), .edge_hit_o(edge_hit_w), .cap_evt_o(cap_evt_w)
  );

  capture_reg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .cap_evt_i(cap_evt_w), .count_i(count_i),
    .top_mode_i(top_mode_i), .wr_i(wr_cap_i), .wr_data_i(wr_data_i),
    .cap_q_o(cap_val_o)
  );

  capture_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(cap_evt_w), .clr_i(flag_clr_i),
    .irq_en_i(irq_en_i), .flag_o(cap_flag_o), .irq_o(irq_o)
  );

  // R8
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode_i && !wr_cap_i) |=> $stable(cap_val_o));

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cap_flag_o && irq_en_i));

endmodule

// File: tb/capture_unit_test.sv
module capture_unit_test;
  localparam int PERIOD = 10;
  localparam int W      = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_pin_i = 1'b0;
  logic         edge_rise_i = 1'b1;
  logic         top_mode_i = 1'b0;
  logic [W-1:0] count_i = '0;
  logic         wr_cap_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         flag_clr_i = 1'b0;
  logic         irq_en_i = 1'b0;
  logic [W-1:0] cap_val_o;
  logic         cap_flag_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_cap = '0;
  logic         exp_flag = 1'b0;
  int unsigned  seed_v;

  always #(PERIOD/2) clk = ~clk;

  capture_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_pin_i(cap_pin_i), .edge_rise_i(edge_rise_i),
    .top_mode_i(top_mode_i), .count_i(count_i), .wr_cap_i(wr_cap_i),
    .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o), .irq_o(irq_o)
  );

  // Bench view of the edge rule, written from R2/R3.
  function automatic logic wants_capture(logic sel, logic old_lvl, logic new_lvl);
    if (old_lvl == new_lvl) return 1'b0;
    return (sel == 1'b1) ? (new_lvl == 1'b1) : (new_lvl == 1'b0);
  endfunction

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_outputs(input string req);
    check(cap_val_o == exp_cap, req, cap_val_o, exp_cap);
    check(cap_flag_o == exp_flag, req, {15'd0, cap_flag_o}, {15'd0, exp_flag});
    check(irq_o == (exp_flag & irq_en_i), {req, "/R7"}, {15'd0, irq_o},
          {15'd0, exp_flag & irq_en_i});
  endtask

  // Moves the pin at a negedge, walks three edges; optional clear at the third.
  task automatic send_edge(input logic new_lvl, input logic sel, input logic clr_at_hit,
                           input string req);
    logic hit;
    logic [W-1:0] c3;
    hit = wants_capture(sel, cap_pin_i, new_lvl) & ~top_mode_i;
    edge_rise_i = sel;
    cap_pin_i   = new_lvl;
    count_i     = W'($urandom);
    @(posedge clk); @(negedge clk);
    count_i = W'($urandom);
    @(posedge clk); @(negedge clk);
    // R4: nothing visible yet after two edges
    check(cap_flag_o == exp_flag, "R4 early", {15'd0, cap_flag_o}, {15'd0, exp_flag});
    c3 = W'($urandom);
    count_i    = c3;
    flag_clr_i = clr_at_hit;
    @(posedge clk); @(negedge clk);
    flag_clr_i = 1'b0;
    if (hit) begin
      exp_cap  = c3;
      exp_flag = 1'b1;
    end else if (clr_at_hit) begin
      exp_flag = 1'b0;
    end
    check_outputs(req);
    @(posedge clk); @(negedge clk);
    check_outputs(req);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    flag_clr_i = 1'b0;
    exp_flag = 1'b0;
    check_outputs("R6 clear");
  endtask

  task automatic write_cap(input logic [W-1:0] d, input string req);
    wr_cap_i  = 1'b1;
    wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_cap_i = 1'b0;
    if (top_mode_i) exp_cap = d;
    check_outputs(req);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'h1c2b);
    repeat (3) @(negedge clk);
    // R1
    check_outputs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after release");

    // R2 rising select, rise then fall
    irq_en_i = 1'b1;
    send_edge(1'b1, 1'b1, 1'b0, "R2 rise");
    send_edge(1'b0, 1'b1, 1'b0, "R2 fall ignored");
    clear_flag();
    // R3 falling select
    send_edge(1'b1, 1'b0, 1'b0, "R3 rise ignored");
    send_edge(1'b0, 1'b0, 1'b0, "R3 fall");
    // R5 overwrite while flag set
    send_edge(1'b1, 1'b1, 1'b0, "R5 overwrite");
    // R7 enable off hides the request
    irq_en_i = 1'b0;
    @(negedge clk);
    check_outputs("R7 disabled");
    irq_en_i = 1'b1;
    // R6 set wins over clear
    send_edge(1'b0, 1'b0, 1'b1, "R6 set wins");
    // R6 clear with no capture at the same edge
    send_edge(1'b0, 1'b0, 1'b1, "R6 clear alone");
    // R10 select change with pin steady
    send_edge(1'b0, 1'b1, 1'b0, "R10 select to rise");
    send_edge(1'b0, 1'b0, 1'b0, "R10 select to fall");
    // R9 write ignored outside TOP mode
    write_cap(16'hA5A5, "R9 ignored");
    // R8 TOP mode blocks capture
    top_mode_i = 1'b1;
    send_edge(1'b1, 1'b1, 1'b0, "R8 blocked rise");
    send_edge(1'b0, 1'b0, 1'b0, "R8 blocked fall");
    write_cap(16'h1234, "R9 load");
    write_cap(16'hFFFF, "R9 load max");
    send_edge(1'b1, 1'b1, 1'b0, "R8 blocked again");
    // R10 leave TOP mode with pin steady high
    top_mode_i = 1'b0;
    send_edge(1'b1, 1'b1, 1'b0, "R10 leave top");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic lvl, sel, clr;
      lvl = 1'($urandom);
      sel = 1'($urandom);
      clr = (($urandom % 4) == 0);
      irq_en_i = 1'($urandom);
      if (($urandom % 8) == 0) top_mode_i = ~top_mode_i;
      if (($urandom % 6) == 0) write_cap(W'($urandom), "R9 random");
      send_edge(lvl, sel, clr, "R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule